// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table held in ordinary memory. The page size is 1 KiB. The lowest 10 bits of the logical address pass through unchanged as the byte offset. The upper 22 bits are the page number. Its top 12 bits select an entry in the outer table, and its next 10 bits select an entry in the inner table that the outer entry points to. The two reads depend on each other: the inner read cannot be formed until the outer entry has come back.

A requester presents one address at a time, together with the base address of the outer table. The walker then issues its reads through a single memory read port. That port has a request handshake and accepts a response after any number of cycles. When the walk is over, the walker returns a one-cycle response that carries either the physical address or a fault code naming the level whose entry was invalid. An invalid outer entry ends the walk at once, so the inner table is never read.

Each table entry is 32 bits wide. Bit 0 is the valid flag. In an outer entry, bits 31:12 give the inner table's address bits 31:12; its low 12 address bits are zero. In an inner entry, bits 31:10 are the frame number. The remaining bits of both entries are ignored.

Top module: `pt_walker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the walker returns to idle: `req_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first read of a walk goes to address `base + 4 * va[31:20]`, where `base` is the value of `table_base` in the cycle the request was accepted.
- R3: The second read goes to address `{outer[31:12], 12'b0} + 4 * va[19:10]`. It is issued only after the outer entry has returned, and there is never more than one read outstanding.
- R4: If bit 0 of the outer entry is 0, the walk makes exactly one read and responds with `resp_fault` = 1 (outer level) and `resp_paddr` = 0.
- R5: If the outer entry is valid and bit 0 of the inner entry is 0, the walk makes exactly two reads and responds with `resp_fault` = 2 (inner level) and `resp_paddr` = 0.
- R6: If both entries are valid, the response has `resp_fault` = 0 and `resp_paddr = {inner[31:10], va[9:0]}`. Entry bits 9:1, and outer bits 11:1, have no effect.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the read request stays raised and its address does not change.
- R8: `req_ready` is low from the cycle after a request is accepted until the response has been given. Requests presented in that time are ignored.
- R9: Each accepted request produces exactly one response, and `resp_valid` is high for a single cycle.
- R10: Changes on `table_base` after acceptance have no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A translation request is presented |
| req_ready | output | 1 | The walker is idle and can accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| table_base | input | 32 | Byte address of the outer table; sampled when a request is accepted |
| resp_valid | output | 1 | One-cycle pulse that marks the end of a walk |
| resp_fault | output | 2 | 0 = success, 1 = outer entry invalid, 2 = inner entry invalid |
| resp_paddr | output | 32 | Physical address on success, 0 on a fault |
| mem_req_valid | output | 1 | A table read is requested |
| mem_req_ready | input | 1 | The memory accepts the read in this cycle |
| mem_req_addr | output | 32 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data is returned in this cycle |
| mem_rsp_data | input | 32 | The table entry that was read |

## Verification
The situations hardest to reach from the ports involve overlap in time. One is a request that arrives while a walk is still in flight. Another is a change of table base after acceptance. A third is a read request held back by the memory for several cycles. The bench therefore keeps `req_valid` high and changes both the address and `table_base` for the whole walk. Its memory model spaces out its grants and varies its response delay from walk to walk. The table contents are generated arithmetically from the indices, so a sweep of outer indices across the whole 12-bit range meets both kinds of fault and plain successes. Each outcome is predicted from the same formula.

// File: rtl/pt_walker_pkg.sv
// Shared definitions for the two-level page table walker.
// Assumes 4-byte table entries with the valid flag in bit 0.
package pt_walker_pkg;

    // Walk sequencer states
    typedef enum logic [2:0] {
        WS_IDLE,
        WS_OUTER_REQ,
        WS_OUTER_WAIT,
        WS_INNER_REQ,
        WS_INNER_WAIT,
        WS_DONE
    } walk_state_e;

    // Fault codes reported with each response
    localparam logic [1:0] FAULT_NONE  = 2'd0;
    localparam logic [1:0] FAULT_OUTER = 2'd1;
    localparam logic [1:0] FAULT_INNER = 2'd2;

    // Entry layout and size
    localparam int unsigned PTE_VALID_BIT  = 0;
    localparam int unsigned PTE_BYTES_LOG2 = 2;

endpackage

// File: rtl/ptw_field_split.sv
// Splits a logical address into its outer index, inner index and page offset.
// Assumes the outer index takes all bits above the inner index.
module ptw_field_split #(
    parameter int unsigned VA_W     = 32,
    parameter int unsigned OFF_W    = 10,
    parameter int unsigned IN_IDX_W = 10,
    localparam int unsigned OUT_IDX_W = VA_W - OFF_W - IN_IDX_W
) (
    input  logic [VA_W-1:0]      vaddr,
    output logic [OUT_IDX_W-1:0] outer_idx,
    output logic [IN_IDX_W-1:0]  inner_idx,
    output logic [OFF_W-1:0]     offset
);

    // Pure field extraction; no logic depth beyond wiring
    always_comb begin
        outer_idx = vaddr[VA_W-1 -: OUT_IDX_W];
        inner_idx = vaddr[OFF_W +: IN_IDX_W];
        offset    = vaddr[OFF_W-1:0];
    end

endmodule

// File: rtl/ptw_addr_form.sv
// Forms the table read addresses and the final physical address from the
// walk registers. Assumes tables are aligned to their own size.
module ptw_addr_form
    import pt_walker_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned PA_W      = 32,
    parameter int unsigned OFF_W     = 10,
    parameter int unsigned IN_IDX_W  = 10,
    parameter int unsigned OUT_IDX_W = 12,
    parameter int unsigned TBL_LSB   = 12,
    parameter int unsigned TBL_W     = 20,
    parameter int unsigned FRAME_W   = 22
) (
    input  logic [AW-1:0]        base_q,
    input  logic [TBL_W-1:0]     tbl_q,
    input  logic [FRAME_W-1:0]   frame_q,
    input  logic [OUT_IDX_W-1:0] outer_idx,
    input  logic [IN_IDX_W-1:0]  inner_idx,
    input  logic [OFF_W-1:0]     offset,
    input  logic                 use_inner,
    input  logic [1:0]           fault,
    output logic [AW-1:0]        mem_addr,
    output logic [PA_W-1:0]      paddr
);

    logic [AW-1:0] outer_addr;
    logic [AW-1:0] inner_base;
    logic [AW-1:0] inner_addr;

    // Entry addresses: table base plus index scaled by the entry size
    always_comb begin
        outer_addr = base_q + (AW'(outer_idx) << PTE_BYTES_LOG2);
        inner_base = AW'({tbl_q, {TBL_LSB{1'b0}}});
        inner_addr = inner_base + (AW'(inner_idx) << PTE_BYTES_LOG2);
        mem_addr   = use_inner ? inner_addr : outer_addr;
    end

    // Physical address: frame number above the untouched offset, zero on fault
    always_comb begin
        paddr = (fault == FAULT_NONE) ? PA_W'({frame_q, offset}) : '0;
    end

endmodule

// File: rtl/ptw_ctrl.sv
// Sequences one walk: accept, outer read, optional inner read, respond.
// Assumes the memory returns data no earlier than the cycle after a read
// is accepted, and at most one response per read.
module ptw_ctrl
    import pt_walker_pkg::*;
#(
    parameter int unsigned VA_W    = 32,
    parameter int unsigned AW      = 32,
    parameter int unsigned PTE_W   = 32,
    parameter int unsigned TBL_LSB = 12,
    parameter int unsigned FRAME_W = 22,
    localparam int unsigned TBL_W     = PTE_W - TBL_LSB,
    localparam int unsigned FRAME_LSB = PTE_W - FRAME_W,
    localparam int unsigned LOW_SPARE = (FRAME_LSB < TBL_LSB) ? FRAME_LSB : TBL_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [AW-1:0]      table_base,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_data,
    output logic               req_ready,
    output logic               mem_req_valid,
    output logic               mem_req_inner,
    output logic               resp_valid,
    output logic [1:0]         resp_fault,
    output logic [VA_W-1:0]    vaddr_q,
    output logic [AW-1:0]      base_q,
    output logic [TBL_W-1:0]   tbl_q,
    output logic [FRAME_W-1:0] frame_q
);

    walk_state_e state_q;
    walk_state_e state_d;
    logic [1:0]  fault_q;
    logic        entry_ok;
    logic        unused_pte_bits;

    assign entry_ok        = mem_rsp_data[PTE_VALID_BIT];
    assign unused_pte_bits = ^mem_rsp_data[LOW_SPARE-1:1];

    // Next-state choice for the walk sequencer
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:       if (req_valid)     state_d = WS_OUTER_REQ;
            WS_OUTER_REQ:  if (mem_req_ready) state_d = WS_OUTER_WAIT;
            WS_OUTER_WAIT: if (mem_rsp_valid) state_d = entry_ok ? WS_INNER_REQ : WS_DONE;
            WS_INNER_REQ:  if (mem_req_ready) state_d = WS_INNER_WAIT;
            WS_INNER_WAIT: if (mem_rsp_valid) state_d = WS_DONE;
            WS_DONE:                          state_d = WS_IDLE;
            default:                          state_d = WS_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // Capture request, table entries and fault code as the walk advances
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            base_q  <= '0;
            tbl_q   <= '0;
            frame_q <= '0;
            fault_q <= FAULT_NONE;
        end else begin
            if (state_q == WS_IDLE && req_valid) begin
                vaddr_q <= req_vaddr;
                base_q  <= table_base;
                fault_q <= FAULT_NONE;
            end
            if (state_q == WS_OUTER_WAIT && mem_rsp_valid) begin
                tbl_q <= mem_rsp_data[PTE_W-1:TBL_LSB];
                if (!entry_ok) fault_q <= FAULT_OUTER;
            end
            if (state_q == WS_INNER_WAIT && mem_rsp_valid) begin
                frame_q <= mem_rsp_data[PTE_W-1 -: FRAME_W];
                if (!entry_ok) fault_q <= FAULT_INNER;
            end
        end
    end

    // Handshake outputs decoded from the state
    always_comb begin
        req_ready     = (state_q == WS_IDLE);
        mem_req_valid = (state_q == WS_OUTER_REQ) || (state_q == WS_INNER_REQ);
        mem_req_inner = (state_q == WS_INNER_REQ);
        resp_valid    = (state_q == WS_DONE);
        resp_fault    = fault_q;
    end

endmodule

// File: rtl/pt_walker.sv
// Top of the two-level page table walker. One walk at a time; the table
// base is sampled with the request. Entries are PTE_W bits with bit 0 valid.
module pt_walker #(
    parameter int unsigned VA_W     = 32,
    parameter int unsigned PA_W     = 32,
    parameter int unsigned PTE_W    = 32,
    parameter int unsigned OFF_W    = 10,
    parameter int unsigned IN_IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  table_base,
    output logic             resp_valid,
    output logic [1:0]       resp_fault,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);

    localparam int unsigned OUT_IDX_W = VA_W - OFF_W - IN_IDX_W;
    localparam int unsigned FRAME_W   = PA_W - OFF_W;
    localparam int unsigned TBL_LSB   = IN_IDX_W + pt_walker_pkg::PTE_BYTES_LOG2;
    localparam int unsigned TBL_W     = PTE_W - TBL_LSB;

    logic [VA_W-1:0]      vaddr_q;
    logic [PA_W-1:0]      base_q;
    logic [TBL_W-1:0]     tbl_q;
    logic [FRAME_W-1:0]   frame_q;
    logic                 mem_req_inner;
    logic [OUT_IDX_W-1:0] outer_idx;
    logic [IN_IDX_W-1:0]  inner_idx;
    logic [OFF_W-1:0]     offset;

    ptw_ctrl #(
        .VA_W    (VA_W),
        .AW      (PA_W),
        .PTE_W   (PTE_W),
        .TBL_LSB (TBL_LSB),
        .FRAME_W (FRAME_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .table_base    (table_base),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_inner (mem_req_inner),
        .resp_valid    (resp_valid),
        .resp_fault    (resp_fault),
        .vaddr_q       (vaddr_q),
        .base_q        (base_q),
        .tbl_q         (tbl_q),
        .frame_q       (frame_q)
    );

    ptw_field_split #(
        .VA_W     (VA_W),
        .OFF_W    (OFF_W),
        .IN_IDX_W (IN_IDX_W)
    ) u_split (
        .vaddr     (vaddr_q),
        .outer_idx (outer_idx),
        .inner_idx (inner_idx),
        .offset    (offset)
    );

    ptw_addr_form #(
        .AW        (PA_W),
        .PA_W      (PA_W),
        .OFF_W     (OFF_W),
        .IN_IDX_W  (IN_IDX_W),
        .OUT_IDX_W (OUT_IDX_W),
        .TBL_LSB   (TBL_LSB),
        .TBL_W     (TBL_W),
        .FRAME_W   (FRAME_W)
    ) u_addr (
        .base_q    (base_q),
        .tbl_q     (tbl_q),
        .frame_q   (frame_q),
        .outer_idx (outer_idx),
        .inner_idx (inner_idx),
        .offset    (offset),
        .use_inner (mem_req_inner),
        .fault     (resp_fault),
        .mem_addr  (mem_req_addr),
        .paddr     (resp_paddr)
    );

endmodule

// File: rtl/pt_walker_chk.sv
// Protocol checker for the page table walker, attached by bind.
// Tracks walk occupancy and read counts from the ports alone.
module pt_walker_chk #(
    parameter int unsigned OFF_W = 10,
    parameter int unsigned AW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OFF_W-1:0] acc_off,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [AW-1:0]    mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             resp_valid,
    input logic [1:0]       resp_fault,
    input logic [OFF_W-1:0] resp_off
);

    logic             busy_q;
    logic             pend_q;
    logic [1:0]       reads_q;
    logic [OFF_W-1:0] off_q;

    // Shadow state: walk in flight, read outstanding, reads this walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            pend_q  <= 1'b0;
            reads_q <= '0;
            off_q   <= '0;
        end else begin
            if (req_valid && req_ready) begin
                busy_q  <= 1'b1;
                reads_q <= '0;
                off_q   <= acc_off;
            end else if (resp_valid) begin
                busy_q <= 1'b0;
            end
            if (mem_req_valid && mem_req_ready) begin
                pend_q <= 1'b1;
                if (reads_q != 2'd3) reads_q <= reads_q + 2'd1;
            end else if (mem_rsp_valid) begin
                pend_q <= 1'b0;
            end
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R3
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !pend_q);

    // R4
    outer_fault_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == 2'd1) |-> (reads_q == 2'd1));

    // R5
    inner_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 2'd1) |-> (reads_q == 2'd2));

    // R6
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == 2'd0) |-> (resp_off == off_q));

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R9
    resp_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> busy_q);

endmodule

bind pt_walker pt_walker_chk #(
    .OFF_W (OFF_W),
    .AW    (PA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .acc_off       (req_vaddr[OFF_W-1:0]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .resp_valid    (resp_valid),
    .resp_fault    (resp_fault),
    .resp_off      (resp_paddr[OFF_W-1:0])
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [31:0] table_base;
    logic        resp_valid;
    logic [1:0]  resp_fault;
    logic [31:0] resp_paddr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    always #2.5 clk = ~clk;

    pt_walker u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .table_base    (table_base),
        .resp_valid    (resp_valid),
        .resp_fault    (resp_fault),
        .resp_paddr    (resp_paddr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    int          lat    = 1;
    bit          stall_mode = 1'b0;
    logic [31:0] walk_base = 32'h0010_0000;
    int          rd_cnt = 0;
    logic [31:0] rd_addr0, rd_addr1, cur_addr;
    bit          seq_err = 1'b0;
    int          walk_no = 0;

    // Table contents generated from indices
    function automatic logic outer_ok(int oi);
        return (oi % 5) != 4;
    endfunction

    function automatic logic inner_ok(int oi, int ii);
        return ((oi + ii) % 3) != 0;
    endfunction

    function automatic logic [21:0] frame_of(int oi, int ii);
        return 22'((oi * 1031) ^ (ii * 37) ^ 32'h2A5A5);
    endfunction

    function automatic logic [31:0] model(logic [31:0] a);
        int idx;
        if (a >= 32'h4000_0000)
            return {frame_of(int'(a[23:12]), int'(a[11:2])), 9'h0AA,
                    inner_ok(int'(a[23:12]), int'(a[11:2]))};
        idx = int'((a - walk_base) >> 2);
        if (a < walk_base || idx > 4095) return 32'hDEAD_BEE0;
        return {20'(32'h40000 + idx), 11'h555, outer_ok(idx)};
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model: grants, latency and read logging, all at falling edges
    initial begin
        int cnt = 0;
        int stall_ctr = 0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                if (mem_req_valid) seq_err = 1'b1;
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = model(cur_addr);
                end
            end else begin
                stall_ctr++;
                mem_req_ready = !stall_mode || (stall_ctr % 3 == 2);
                if (mem_req_valid && mem_req_ready) begin
                    if (rd_cnt == 0) rd_addr0 = mem_req_addr;
                    else if (rd_cnt == 1) rd_addr1 = mem_req_addr;
                    rd_cnt++;
                    cur_addr = mem_req_addr;
                    cnt = lat;
                end
            end
        end
    end

    task automatic walk(logic [31:0] va, logic [31:0] base);
        int oi = int'(va[31:20]);
        int ii = int'(va[19:10]);
        int n  = 0;
        int extra = 0;
        logic [1:0]  exp_f;
        logic [31:0] exp_pa;
        int          exp_rd;
        @(negedge clk);
        rd_cnt = 0; seq_err = 1'b0; walk_base = base;
        req_vaddr = va; table_base = base; req_valid = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b0, "R8", "ready after accept", 32'(req_ready), 32'd0);
        // R8 R10: keep a different request and base on the port while busy
        req_vaddr  = ~va;
        table_base = base ^ 32'h0F0F_0000;
        while (!resp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        check(resp_valid == 1'b1, "R9", "response arrived", 32'(resp_valid), 32'd1);
        exp_f  = !outer_ok(oi) ? 2'd1 : (!inner_ok(oi, ii) ? 2'd2 : 2'd0);
        exp_pa = (exp_f == 2'd0) ? {frame_of(oi, ii), va[9:0]} : 32'd0;
        exp_rd = outer_ok(oi) ? 2 : 1;
        if (exp_f == 2'd1)      check(resp_fault == exp_f, "R4", "outer fault code", 32'(resp_fault), 32'(exp_f));
        else if (exp_f == 2'd2) check(resp_fault == exp_f, "R5", "inner fault code", 32'(resp_fault), 32'(exp_f));
        else                    check(resp_fault == exp_f, "R6", "success code", 32'(resp_fault), 32'(exp_f));
        check(resp_paddr == exp_pa, "R6", "physical address", resp_paddr, exp_pa);
        check(rd_addr0 == base + 32'(oi * 4), "R2", "outer read address", rd_addr0, base + 32'(oi * 4));
        if (exp_rd == 2)
            check(rd_addr1 == 32'h4000_0000 + 32'(oi << 12) + 32'(ii * 4), "R3", "inner read address",
                  rd_addr1, 32'h4000_0000 + 32'(oi << 12) + 32'(ii * 4));
        check(seq_err == 1'b0, "R3", "read while one outstanding", 32'(seq_err), 32'd0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (resp_valid) extra++;
        end
        check(extra == 0, "R9", "extra responses", 32'(extra), 32'd0);
        check(rd_cnt == exp_rd, exp_rd == 1 ? "R4" : "R5", "read count", 32'(rd_cnt), 32'(exp_rd));
        check(req_ready == 1'b1, "R8", "ready after response", 32'(req_ready), 32'd1);
        walk_no++;
        lat        = 1 + (walk_no % 4);
        stall_mode = ((walk_no / 4) % 2) == 1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Stimulus and sweep
    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; table_base = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 32'd1);
        check(resp_valid == 1'b0, "R1", "resp in reset", 32'(resp_valid), 32'd0);
        check(mem_req_valid == 1'b0, "R1", "mem req in reset", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        // Corners: lowest and highest indices and offsets
        walk(32'h0000_0000, 32'h0010_0000);
        walk(32'hFFFF_FFFF, 32'h0010_0000);
        walk({12'd0, 10'd1023, 10'd1023}, 32'h0123_4000);
        walk({12'd4095, 10'd0, 10'd0}, 32'h0123_4000);
        walk({12'd4, 10'd7, 10'h155}, 32'h0010_0000);   // outer fault
        walk({12'd1, 10'd2, 10'h2AA}, 32'h0010_0000);   // inner fault
        // Sweep outer indices across the whole range
        for (int oi = 0; oi < 4096; oi += 37) begin
            for (int k = 0; k < 2; k++) begin
                int ii  = (oi * 13 + k * 101) % 1024;
                int off = (oi * 7 + ii + k * 511) % 1024;
                walk({12'(oi), 10'(ii), 10'(off)}, k == 0 ? 32'h0010_0000 : 32'h0123_4000);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule